// File: doc/BRIEF.md
# Event-Selectable Performance Counter Unit

This block gives software a view of how the pipeline, the data cache and the two translation buffers behave. It holds three counters. A cycle counter measures total running time. Two event counters are fed, as a pair, by whichever group of event strobes the selected mode picks. The modes are: data-dependency stalls with data cache writebacks, instruction TLB efficiency, and data TLB efficiency. Software turns ratios such as miss rate or cycles per instruction into numbers from the counts it reads.

The pipeline, caches and TLBs present one strobe per event per cycle. Data accesses come in as a small per-cycle count, so one clock can add several. The requesting logic already knows how many accesses an operation makes: one per register of a multi-register transfer, two for a double-word load. A plain register port, with a write strobe and a combinational read, reads and writes the control word and all three counters. The block has no data stream, so it has no valid/ready handshake, and nothing is ever back-pressured.

Top module: `perfmon_unit`

## Requirements
- R1: After reset all three counters, the overflow flags, the enable bit and the mode are zero.
- R2: While enabled, the cycle counter adds one every clock. While disabled, all three counters hold, unless software writes them.
- R3: In mode 0, event counter 0 adds one for each cycle with a data-dependency stall strobe. Event counter 1 adds one for each data cache writeback strobe, whether the writeback comes from a dirty eviction or from a clean operation.
- R4: In mode 1, event counter 0 adds one for each executed-instruction strobe, and squashed instructions never raise that strobe. Event counter 1 adds one for each instruction TLB table-walk strobe, but only while the instruction TLB enable input is 1.
- R5: In mode 2, event counter 0 adds the data access count input (0 to 16) each cycle. Event counter 1 adds one for each data TLB table-walk strobe, but only while the data TLB enable input is 1.
- R6: In mode 3 both event counters hold.
- R7: Every counter wraps modulo 2^CNT_W. A wrap sets a sticky flag: control bit 4 for the cycle counter, bit 5 for event counter 0, bit 6 for event counter 1. Writing 1 to a flag bit clears it, and a wrap in the same cycle wins over the clear.
- R8: A control write that changes the mode clears both event counters on the next edge. Events seen in that cycle are dropped.
- R9: A write to a counter loads the written value. It overrides any event or cycle increment in the same cycle and sets no flag.
- R10: Writing 1 to control bit 1 clears all three counters on the next edge. The bit always reads as 0.
- R11: Register map by address: 0 is the control word (bit 0 enable, bits 3:2 mode, flags in bits 6:4), 1 is the cycle counter, 2 is event counter 0, 3 is event counter 1. Reads are combinational. Control changes take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_stall | input | 1 | Data-dependency stall this cycle |
| ev_wb | input | 1 | Data cache writeback this cycle |
| ev_insn_exec | input | 1 | Instruction executed this cycle |
| ev_itlb_walk | input | 1 | Instruction TLB table walk started |
| itlb_on | input | 1 | Instruction TLB enabled |
| ev_dacc_cnt | input | ACC_W | Data accesses this cycle (0 to 16) |
| ev_dtlb_walk | input | 1 | Data TLB table walk started |
| dtlb_on | input | 1 | Data TLB enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data |
| cyc_cnt | output | CNT_W | Cycle counter value |
| evt0_cnt | output | CNT_W | Event counter 0 value |
| evt1_cnt | output | CNT_W | Event counter 1 value |
| ovf_flags | output | 3 | Sticky wrap flags {evt1, evt0, cycle} |

## Verification
The bench builds the block with CNT_W set to 8 and ACC_W at its default of 5. At that width every counter wraps within a few hundred cycles, and data-access bursts of up to 16 wrap event counter 0 within tens of cycles. This makes the sticky flags, the clear-versus-wrap race and the modulo behaviour reachable in a short run. The access count can still reach its full 0 to 16 range, so the multi-count path is tested at its upper bound.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  typedef enum logic [1:0] {
    PM_STALL_WB = 2'd0,
    PM_ITLB     = 2'd1,
    PM_DTLB     = 2'd2,
    PM_IDLE     = 2'd3
  } pm_mode_e;

  localparam int NUM_CNT   = 3;
  localparam int CTL_EN    = 0;
  localparam int CTL_CLRA  = 1;
  localparam int CTL_MODE  = 2;
  localparam int CTL_FLAG  = 4;
  localparam int CTL_BITS  = 7;
  localparam logic [1:0] ADDR_CTL = 2'd0;
endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum    = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);
  assign wrap_o = en_i & ~ld_i & ~clr_i & sum[CNT_W];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/perfmon_evsel.sv
module perfmon_evsel
  import perfmon_pkg::*;
#(
  parameter int ACC_W = 5
) (
  input  pm_mode_e         mode_i,
  input  logic             ev_stall,
  input  logic             ev_wb,
  input  logic             ev_insn_exec,
  input  logic             ev_itlb_walk,
  input  logic             itlb_on,
  input  logic [ACC_W-1:0] ev_dacc_cnt,
  input  logic             ev_dtlb_walk,
  input  logic             dtlb_on,
  output logic [ACC_W-1:0] inc0_o,
  output logic [ACC_W-1:0] inc1_o
);
  always_comb begin
    inc0_o = '0;
    inc1_o = '0;
    case (mode_i)
      PM_STALL_WB: begin
        inc0_o = ACC_W'(ev_stall);
        inc1_o = ACC_W'(ev_wb);
      end
      PM_ITLB: begin
        inc0_o = ACC_W'(ev_insn_exec);
        inc1_o = ACC_W'(ev_itlb_walk & itlb_on);
      end
      PM_DTLB: begin
        inc0_o = ev_dacc_cnt;
        inc1_o = ACC_W'(ev_dtlb_walk & dtlb_on);
      end
      default: begin
        inc0_o = '0;
        inc1_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
  import perfmon_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [1:0]          addr_i,
  input  logic [CTL_BITS-1:0] wdata_i,
  input  logic [NUM_CNT-1:0]  wrap_i,
  output logic                run_o,
  output pm_mode_e            mode_o,
  output logic [NUM_CNT-1:0]  flags_o,
  output logic                clr_all_o,
  output logic                mode_chg_o
);
  logic                ctl_wr;
  logic [NUM_CNT-1:0]  flag_clr;
  pm_mode_e            new_mode;

  assign ctl_wr     = wr_i & (addr_i == ADDR_CTL);
  assign new_mode   = pm_mode_e'(wdata_i[CTL_MODE +: 2]);
  assign clr_all_o  = ctl_wr & wdata_i[CTL_CLRA];
  assign mode_chg_o = ctl_wr & (new_mode != mode_o);
  assign flag_clr   = ctl_wr ? wdata_i[CTL_FLAG +: NUM_CNT] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o   <= 1'b0;
      mode_o  <= PM_STALL_WB;
      flags_o <= '0;
    end else begin
      if (ctl_wr) begin
        run_o  <= wdata_i[CTL_EN];
        mode_o <= new_mode;
      end
      flags_o <= (flags_o & ~flag_clr) | wrap_i;
    end
  end
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ACC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_stall,
  input  logic             ev_wb,
  input  logic             ev_insn_exec,
  input  logic             ev_itlb_walk,
  input  logic             itlb_on,
  input  logic [ACC_W-1:0] ev_dacc_cnt,
  input  logic             ev_dtlb_walk,
  input  logic             dtlb_on,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] cyc_cnt,
  output logic [CNT_W-1:0] evt0_cnt,
  output logic [CNT_W-1:0] evt1_cnt,
  output logic [2:0]       ovf_flags
);
  logic               run_en;
  pm_mode_e           mode_q;
  logic [NUM_CNT-1:0] flags;
  logic               clr_all;
  logic               mode_chg;
  logic [NUM_CNT-1:0] wrap;
  logic [ACC_W-1:0]   inc0;
  logic [ACC_W-1:0]   inc1;
  logic [ACC_W-1:0]   inc_arr [NUM_CNT];
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];
  logic [NUM_CNT-1:0] clr_arr;

  perfmon_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata[CTL_BITS-1:0]),
    .wrap_i     (wrap),
    .run_o      (run_en),
    .mode_o     (mode_q),
    .flags_o    (flags),
    .clr_all_o  (clr_all),
    .mode_chg_o (mode_chg)
  );

  perfmon_evsel #(.ACC_W(ACC_W)) u_evsel (
    .mode_i       (mode_q),
    .ev_stall     (ev_stall),
    .ev_wb        (ev_wb),
    .ev_insn_exec (ev_insn_exec),
    .ev_itlb_walk (ev_itlb_walk),
    .itlb_on      (itlb_on),
    .ev_dacc_cnt  (ev_dacc_cnt),
    .ev_dtlb_walk (ev_dtlb_walk),
    .dtlb_on      (dtlb_on),
    .inc0_o       (inc0),
    .inc1_o       (inc1)
  );

  assign inc_arr[0] = ACC_W'(1);
  assign inc_arr[1] = inc0;
  assign inc_arr[2] = inc1;
  assign clr_arr    = {mode_chg | clr_all, mode_chg | clr_all, clr_all};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    perfmon_counter #(.CNT_W(CNT_W), .INC_W(ACC_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_i     (reg_wr && (reg_addr == 2'(i + 1))),
      .ld_val_i (reg_wdata),
      .clr_i    (clr_arr[i]),
      .en_i     (run_en),
      .inc_i    (inc_arr[i]),
      .cnt_o    (cnt_arr[i]),
      .wrap_o   (wrap[i])
    );
  end

  assign cyc_cnt   = cnt_arr[0];
  assign evt0_cnt  = cnt_arr[1];
  assign evt1_cnt  = cnt_arr[2];
  assign ovf_flags = flags;

  always_comb begin
    case (reg_addr)
      2'd1:    reg_rdata = cnt_arr[0];
      2'd2:    reg_rdata = cnt_arr[1];
      2'd3:    reg_rdata = cnt_arr[2];
      default: reg_rdata = CNT_W'({flags, mode_q, 1'b0, run_en});
    endcase
  end
endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk
  import perfmon_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ACC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             run_en,
  input pm_mode_e         mode_q,
  input logic             ev_itlb_walk,
  input logic             itlb_on,
  input logic [ACC_W-1:0] ev_dacc_cnt,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic [CNT_W-1:0] evt0_cnt,
  input logic [CNT_W-1:0] evt1_cnt
);
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !reg_wr |=> (cyc_cnt - $past(cyc_cnt)) == CNT_W'(1)); // R2

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !reg_wr |=> $stable(cyc_cnt) && $stable(evt0_cnt) && $stable(evt1_cnt)); // R2

  AST_ITLB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == PM_ITLB && !itlb_on && !reg_wr |=> $stable(evt1_cnt)); // R4

  AST_DACC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == PM_DTLB && run_en && !reg_wr
      |=> (evt0_cnt - $past(evt0_cnt)) == CNT_W'($past(ev_dacc_cnt))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == PM_IDLE && !reg_wr |=> $stable(evt0_cnt) && $stable(evt1_cnt)); // R6

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_CTL && reg_wdata[CTL_MODE +: 2] != mode_q
      |=> evt0_cnt == '0 && evt1_cnt == '0); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd2 |=> evt0_cnt == $past(reg_wdata)); // R9

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_CTL && reg_wdata[CTL_CLRA]
      |=> cyc_cnt == '0 && evt0_cnt == '0 && evt1_cnt == '0); // R10
endmodule

bind perfmon_unit perfmon_unit_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .run_en       (run_en),
  .mode_q       (mode_q),
  .ev_itlb_walk (ev_itlb_walk),
  .itlb_on      (itlb_on),
  .ev_dacc_cnt  (ev_dacc_cnt),
  .cyc_cnt      (cyc_cnt),
  .evt0_cnt     (evt0_cnt),
  .evt1_cnt     (evt1_cnt)
);

// File: tb/test_perfmon_unit.sv
`timescale 1ns/1ps
module test_perfmon_unit;
  localparam int W = 8;
  localparam int A = 5;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_stall = 0, ev_wb = 0, ev_insn_exec = 0, ev_itlb_walk = 0, itlb_on = 0;
  logic [A-1:0] ev_dacc_cnt = '0;
  logic ev_dtlb_walk = 0, dtlb_on = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata, cyc_cnt, evt0_cnt, evt1_cnt;
  logic [2:0] ovf_flags;

  always #2.5 clk = ~clk;

  perfmon_unit #(.CNT_W(W), .ACC_W(A)) i_perfmon_unit (.*);

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";
  bit started = 0, done = 0;

  int m_cyc = 0, m_c0 = 0, m_c1 = 0, m_flags = 0, m_en = 0, m_mode = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_c0 = 0; m_c1 = 0; m_flags = 0; m_en = 0; m_mode = 0;
    end else begin
      int i0, i1, wraps, clr, d, nmode;
      bit cw;
      started = 1;
      d = int'(reg_wdata);
      cw = reg_wr && reg_addr == 0;
      nmode = (d >> 2) & 3;
      case (m_mode)
        0: begin i0 = int'(ev_stall); i1 = int'(ev_wb); end
        1: begin i0 = int'(ev_insn_exec); i1 = int'(ev_itlb_walk && itlb_on); end
        2: begin i0 = int'(ev_dacc_cnt); i1 = int'(ev_dtlb_walk && dtlb_on); end
        default: begin i0 = 0; i1 = 0; end
      endcase
      wraps = 0;
      if (reg_wr && reg_addr == 1) m_cyc = d;
      else if (cw && d[1]) m_cyc = 0;
      else if (m_en != 0) begin
        m_cyc = m_cyc + 1;
        if (m_cyc > MAXV) begin wraps |= 1; m_cyc &= MAXV; end
      end
      if (reg_wr && reg_addr == 2) m_c0 = d;
      else if (cw && (d[1] || nmode != m_mode)) m_c0 = 0;
      else if (m_en != 0) begin
        m_c0 = m_c0 + i0;
        if (m_c0 > MAXV) begin wraps |= 2; m_c0 &= MAXV; end
      end
      if (reg_wr && reg_addr == 3) m_c1 = d;
      else if (cw && (d[1] || nmode != m_mode)) m_c1 = 0;
      else if (m_en != 0) begin
        m_c1 = m_c1 + i1;
        if (m_c1 > MAXV) begin wraps |= 4; m_c1 &= MAXV; end
      end
      clr = cw ? ((d >> 4) & 7) : 0;
      m_flags = (m_flags & ~clr) | wraps;
      if (cw) begin m_en = d & 1; m_mode = nmode; end
    end
  end

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      int rexp;
      case (reg_addr)
        2'd1: rexp = m_cyc;
        2'd2: rexp = m_c0;
        2'd3: rexp = m_c1;
        default: rexp = (m_flags << 4) | (m_mode << 2) | m_en;
      endcase
      check("cyc_cnt", int'(cyc_cnt), m_cyc);
      check("evt0_cnt", int'(evt0_cnt), m_c0);
      check("evt1_cnt", int'(evt1_cnt), m_c1);
      check("ovf_flags", int'(ovf_flags), m_flags);
      check("reg_rdata", int'(reg_rdata), rexp);
    end
  end

  task automatic rand_ev();
    ev_stall     = 1'($urandom);
    ev_wb        = 1'($urandom);
    ev_insn_exec = 1'($urandom);
    ev_itlb_walk = 1'($urandom);
    itlb_on      = 1'($urandom);
    ev_dtlb_walk = 1'($urandom);
    dtlb_on      = 1'($urandom);
    ev_dacc_cnt  = A'($urandom_range(16, 0));
    reg_addr     = 2'($urandom);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      reg_wr = 0;
      rand_ev();
    end
  endtask

  task automatic wreg(int a, int d);
    @(posedge clk); #1;
    rand_ev();
    reg_wr = 1; reg_addr = 2'(a); reg_wdata = W'(d);
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    phase = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    run(3);
    phase = "R11";
    wreg(1, 8'h5A); wreg(2, 8'h33); wreg(3, 8'hC4);
    run(20);
    phase = "R2";
    run(20);
    wreg(0, 1);
    phase = "R3";
    run(200);
    phase = "R8";
    wreg(0, 1 | (1 << 2));
    run(2);
    phase = "R4";
    run(200);
    phase = "R5";
    wreg(0, 1 | (2 << 2));
    run(200);
    phase = "R7";
    wreg(0, 1 | (2 << 2) | (7 << 4));
    run(60);
    wreg(0, 1 | (2 << 2) | (2 << 4));
    run(60);
    phase = "R6";
    wreg(0, 1 | (3 << 2));
    run(60);
    phase = "R9";
    wreg(0, 1 | (2 << 2));
    wreg(2, 8'hF8); wreg(3, 8'h10); wreg(1, 8'hFE);
    run(10);
    phase = "R10";
    wreg(0, 1 | (2 << 2) | 2);
    run(10);
    phase = "R2";
    wreg(0, 2 << 2);
    run(30);
    @(posedge clk); #1 reg_wr = 0;
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule